// File: doc/BRIEF.md
# Dual-Mode PWM Generator with Up/Down Counting

This block produces one pulse-width-modulated output from a 10-bit counter that advances on a prescaled tick. The tick rate is the input clock divided by 1, 2, 4 or 8. A run-time mode input selects one of two counting schemes.

In wrap mode the counter runs from zero up to the period value and then returns to zero. In symmetric mode it climbs to the period value, holds there for a second tick, then descends to zero and holds there for a second tick. This gives a centre-aligned waveform whose period and active width are twice those of wrap mode for the same settings.

Software loads period and duty through a byte-wide write port. Each value is given as a 2-bit upper part and an 8-bit lower part. Writes land in shadow copies. The counter and comparator use working copies, and these reload from the shadows only at the point where a period ends. A polarity input picks the active output level. An enable input stops the generator and holds the output inactive.

Top module: `pwm_dual_mode`

## Requirements
- R1: While `en` is low (and out of reset) the output equals the inactive level `!polarity` and the counter is held at zero. The first tick after `en` rises starts from count zero, so the output is active at once whenever duty is at least zero.
- R2: The prescaler issues one tick every 2^`pre_sel` clocks while enabled: `pre_sel`=0,1,2,3 gives 1,2,4,8 clocks. The counter advances only on a tick.
- R3: With `mode_b2b`=0 the counter counts 0,1,...,P and then returns to 0, where P is the working period. The output is active while count <= D, where D is the working duty. One period is (P+1) ticks and the active part is (D+1) ticks.
- R4: With `mode_b2b`=1 the counter goes up to P, shows P for two consecutive ticks, goes down to 0, and shows 0 for two consecutive ticks. The output is active while count <= D. One period is 2(P+1) ticks and the active part is 2(D+1) ticks, centred on the zero turnaround.
- R5: With `polarity`=1 the active level is high. With `polarity`=0 the active level is low.
- R6: The write port uses these addresses: 0 = period lower byte, 1 = period upper bits, 2 = duty lower byte, 3 = duty upper bits. An upper-bits write stores `wr_data[1:0]` in a holding register and changes nothing else. A lower-byte write commits {held upper bits, `wr_data`} as one 10-bit shadow value.
- R7: The working period and duty copy the shadows only at a period end and while disabled. In wrap mode the period end is the tick that returns the count to 0. In symmetric mode it is the tick that leaves the second 0. A write committed on the same clock as a period end takes effect only at the next period end.
- R8: When D >= P the output stays at the active level for the whole period in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable |
| mode_b2b | input | 1 | 0 = wrap counting, 1 = symmetric up/down counting |
| polarity | input | 1 | Active output level |
| pre_sel | input | 2 | Tick divider select, divide by 2^pre_sel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The collision that matters is a lower-byte commit landing on the same clock as a period end. On that edge the shadow register takes the new value while the working copy loads the old one. The bench provokes this by timing the write from its own model, so that the strobe sits exactly on the tick that wraps the count. It then measures the next two periods at the output pin: the first must still have the old length and the second the new one. A reference model, stepped every clock and compared every clock, also covers mode, polarity and divider changes made while the generator runs.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    ADR_PER_LO  = 2'd0,
    ADR_PER_HI  = 2'd1,
    ADR_DUTY_LO = 2'd2,
    ADR_DUTY_HI = 2'd3
  } reg_addr_e;

  // output level from compare result and chosen active level
  function automatic logic f_level(input logic active, input logic act_high);
    return ~(active ^ act_high);
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_cnt;

  // tick when the low sel bits of the running count are all ones
  function automatic logic f_hit(input logic [PRE_W-1:0] c, input logic [SEL_W-1:0] s);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (32'(s) > i);
    return (c & m) == m;
  endfunction

  assign tick = en && f_hit(pre_cnt, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_cnt <= '0;
    else if (!en) pre_cnt <= '0;
    else          pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              boundary,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  per_w,
  output logic [CNT_W-1:0]  duty_w
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [HI_W-1:0]  per_hi, duty_hi;
  logic [CNT_W-1:0] per_s, duty_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_hi  <= '0;
      duty_hi <= '0;
      per_s   <= '0;
      duty_s  <= '0;
      per_w   <= '0;
      duty_w  <= '0;
    end else begin
      if (wr_en) begin
        case (reg_addr_e'(wr_addr))
          ADR_PER_HI:  per_hi  <= wr_data[HI_W-1:0];
          ADR_PER_LO:  per_s   <= {per_hi, wr_data};
          ADR_DUTY_HI: duty_hi <= wr_data[HI_W-1:0];
          ADR_DUTY_LO: duty_s  <= {duty_hi, wr_data};
          default: ;
        endcase
      end
      if (!en || boundary) begin
        per_w  <= per_s;
        duty_w <= duty_s;
      end
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             mode_b2b,
  input  logic [CNT_W-1:0] per_w,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_up,
  output logic             boundary
);
  logic [CNT_W-1:0] nxt_cnt;
  logic             nxt_up;
  logic             at_end;

  always_comb begin
    nxt_cnt = cnt;
    nxt_up  = cnt_up;
    at_end  = 1'b0;
    if (!mode_b2b) begin
      nxt_up = 1'b1;
      if (cnt >= per_w) begin
        nxt_cnt = '0;
        at_end  = 1'b1;
      end else begin
        nxt_cnt = cnt + 1'b1;
      end
    end else if (cnt_up) begin
      if (cnt >= per_w) nxt_up  = 1'b0;
      else              nxt_cnt = cnt + 1'b1;
    end else begin
      if (cnt == '0) begin
        nxt_up = 1'b1;
        at_end = 1'b1;
      end else begin
        nxt_cnt = cnt - 1'b1;
      end
    end
  end

  assign boundary = en && tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      cnt_up <= 1'b1;
    end else if (!en) begin
      cnt    <= '0;
      cnt_up <= 1'b1;
    end else if (tick) begin
      cnt    <= nxt_cnt;
      cnt_up <= nxt_up;
    end
  end
endmodule

// File: rtl/pwm_dual_mode.sv
module pwm_dual_mode
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mode_b2b,
  input  logic              polarity,
  input  logic [SEL_W-1:0]  pre_sel,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              pwm_out
);
  logic             tick;
  logic             boundary;
  logic             cnt_up;
  logic             cmp_hit;
  logic [CNT_W-1:0] cnt, per_w, duty_w;

  pwm_prescaler #(.SEL_W(SEL_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .en(en), .sel(pre_sel), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .mode_b2b(mode_b2b),
    .per_w(per_w), .cnt(cnt), .cnt_up(cnt_up), .boundary(boundary)
  );

  pwm_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .en(en), .boundary(boundary),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .per_w(per_w), .duty_w(duty_w)
  );

  assign cmp_hit = en && (cnt <= duty_w);
  assign pwm_out = f_level(cmp_hit, polarity);
endmodule

// File: rtl/pwm_dual_mode_chk.sv
module pwm_dual_mode_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             mode_b2b,
  input logic             polarity,
  input logic             tick,
  input logic             boundary,
  input logic             pwm_out,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_w,
  input logic [CNT_W-1:0] duty_w
);
  AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0); // R1

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt)); // R2

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_w); // R3

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !mode_b2b && cnt == per_w) |=> cnt == '0); // R3

  AST_B2B_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && mode_b2b) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt + 1'b1 == $past(cnt))); // R4

  AST_WORK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !boundary) |=> ($stable(per_w) && $stable(duty_w))); // R7

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && duty_w >= per_w) |-> pwm_out == polarity); // R8
endmodule

bind pwm_dual_mode pwm_dual_mode_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/pwm_dual_mode_tb_top.sv
module pwm_dual_mode_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       mode_b2b = 1'b0;
  logic       polarity = 1'b1;
  logic [1:0] pre_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dual_mode dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_b2b(mode_b2b), .polarity(polarity),
    .pre_sel(pre_sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out)
  );

  // behavioural reference state
  int m_pre, m_cnt, m_per_w, m_duty_w, m_per_s, m_duty_s, m_per_hi, m_duty_hi;
  bit m_up;

  always @(posedge clk) begin
    int lp, ld, div;
    bit tk, bnd;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_per_w = 0; m_duty_w = 0;
      m_per_s = 0; m_duty_s = 0; m_per_hi = 0; m_duty_hi = 0; m_up = 1;
    end else begin
      lp = m_per_s; ld = m_duty_s;
      if (!en) begin
        m_pre = 0; m_cnt = 0; m_up = 1; m_per_w = lp; m_duty_w = ld;
      end else begin
        div = 1 << pre_sel;
        tk = (m_pre % div) == div - 1;
        m_pre = (m_pre + 1) % 8;
        if (tk) begin
          bnd = 0;
          if (!mode_b2b) begin
            m_up = 1;
            if (m_cnt >= m_per_w) begin m_cnt = 0; bnd = 1; end
            else m_cnt = m_cnt + 1;
          end else if (m_up) begin
            if (m_cnt >= m_per_w) m_up = 0;
            else m_cnt = m_cnt + 1;
          end else if (m_cnt == 0) begin
            m_up = 1; bnd = 1;
          end else m_cnt = m_cnt - 1;
          if (bnd) begin m_per_w = lp; m_duty_w = ld; end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_per_s = m_per_hi * 256 + int'(wr_data);
          2'd1: m_per_hi = int'(wr_data) % 4;
          2'd2: m_duty_s = m_duty_hi * 256 + int'(wr_data);
          default: m_duty_hi = int'(wr_data) % 4;
        endcase
      end
    end
  end

  function automatic bit model_out();
    if (en && m_cnt <= m_duty_w) return polarity;
    return !polarity;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) check(pwm_out == model_out(), cur_req, int'(pwm_out), int'(model_out()));
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_vals(input int per, input int duty);
    wr(2'd1, 8'(per / 256)); wr(2'd0, 8'(per % 256));
    wr(2'd3, 8'(duty / 256)); wr(2'd2, 8'(duty % 256));
  endtask

  // from a negedge with the output active: active clocks and full period clocks
  task automatic span(input bit act, output int hi, output int tot);
    hi = 0; tot = 0;
    while (pwm_out == act) begin hi++; tot++; @(negedge clk); end
    while (pwm_out != act) begin tot++; @(negedge clk); end
  endtask

  task automatic measure(input bit act, output int hi, output int tot);
    @(negedge clk);
    while (pwm_out == act) @(negedge clk);
    while (pwm_out != act) @(negedge clk);
    span(act, hi, tot);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int hi, tot, n;
    bit all_act;
    step(3);
    rst_n = 1'b1;
    step(2);
    cur_req = "R1";
    @(negedge clk); check(pwm_out == 1'b0, "R1", pwm_out, 0);
    polarity = 1'b0; #1;
    check(pwm_out == 1'b1, "R1", pwm_out, 1);
    polarity = 1'b1;

    // wrap mode, divide by 8
    cur_req = "R3";
    set_vals(11, 5);
    pre_sel = 2'd3; step(1); en = 1'b1;
    measure(1'b1, hi, tot);
    check(hi == 48, "R3", hi, 48);
    check(tot == 96, "R3", tot, 96);

    // symmetric mode
    cur_req = "R4";
    step(1); en = 1'b0; mode_b2b = 1'b1; step(2); en = 1'b1;
    measure(1'b1, hi, tot);
    check(hi == 96, "R4", hi, 96);
    check(tot == 192, "R4", tot, 192);

    // polarity low, still symmetric
    cur_req = "R5";
    step(1); polarity = 1'b0;
    measure(1'b0, hi, tot);
    check(hi == 96, "R5", hi, 96);
    check(tot == 192, "R5", tot, 192);
    step(1); polarity = 1'b1;

    // divider settings, wrap mode
    cur_req = "R2";
    step(1); en = 1'b0; mode_b2b = 1'b0; step(1);
    set_vals(3, 1);
    pre_sel = 2'd1; step(1); en = 1'b1;
    measure(1'b1, hi, tot);
    check(tot == 8, "R2", tot, 8);
    check(hi == 4, "R2", hi, 4);
    pre_sel = 2'd2;
    measure(1'b1, hi, tot); measure(1'b1, hi, tot);
    check(tot == 16, "R2", tot, 16);
    pre_sel = 2'd0;
    measure(1'b1, hi, tot); measure(1'b1, hi, tot);
    check(tot == 4, "R2", tot, 4);

    // upper-bits write alone changes nothing
    cur_req = "R6";
    set_vals(11, 5);
    measure(1'b1, hi, tot); measure(1'b1, hi, tot);
    check(tot == 12, "R6", tot, 12);
    wr(2'd1, 8'h01);
    measure(1'b1, hi, tot); measure(1'b1, hi, tot);
    check(tot == 12, "R6", tot, 12);
    wr(2'd0, 8'h05);
    measure(1'b1, hi, tot); measure(1'b1, hi, tot);
    check(tot == 262, "R6", tot, 262);
    check(hi == 6, "R6", hi, 6);

    // commit on the same clock as a period end
    cur_req = "R7";
    set_vals(7, 3);
    measure(1'b1, hi, tot); measure(1'b1, hi, tot);
    check(tot == 8, "R7", tot, 8);
    n = 0;
    while (!(m_cnt == m_per_w && m_per_w == 7) && n < 100) begin step(1); n++; end
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd5;
    step(1); wr_en = 1'b0;
    @(negedge clk);
    span(1'b1, hi, tot);
    check(tot == 8, "R7", tot, 8);
    span(1'b1, hi, tot);
    check(tot == 6, "R7", tot, 6);
    check(hi == 4, "R7", hi, 4);

    // duty at or above period
    cur_req = "R8";
    set_vals(10, 20);
    step(30);
    all_act = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (pwm_out != 1'b1) all_act = 0; end
    check(all_act, "R8", all_act, 1);
    mode_b2b = 1'b1;
    all_act = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (pwm_out != 1'b1) all_act = 0; end
    check(all_act, "R8", all_act, 1);

    // disable mid-run and restart
    cur_req = "R1";
    set_vals(9, 2);
    step(25);
    en = 1'b0;
    @(negedge clk); check(pwm_out == 1'b0, "R1", pwm_out, 0);
    step(3); en = 1'b1;
    @(negedge clk); check(pwm_out == 1'b1, "R1", pwm_out, 1);
    measure(1'b1, hi, tot);
    check(tot == 20, "R4", tot, 20);
    check(hi == 6, "R4", hi, 6);

    step(4);
    finish_run();
  end
endmodule